// File: doc/BRIEF.md
# Microcode Control Store Loader and Writer

This block owns the writable microcode RAM of a microcoded processor: 512 words of 64 bits. Nonvolatile memory cannot keep up with the target cycle rate, so the microsequencer fetches from RAM. After reset the block copies the whole image from a slow image memory into that RAM, one word at a time. Every image read has a fixed latency of `IMG_LAT` cycles. The processor core is held in reset, through `cpu_rst`, until the final word (address 511) is in place.

At run time the store stays writable. A microinstruction raises a write command (`wcs_valid`) that carries a destination taken from the stack pointer and a data word built from four 16-bit general registers. The command uses a valid/ready handshake. A command is taken on a rising edge where `wcs_valid` and `wcs_ready` are both high. While `wcs_ready` is low, the sender must hold its command, and nothing is recorded. `wcs_ready` is low for the whole copy and for the cycle in which an accepted word is being committed. `wcs_busy` marks that commit cycle, so the microsequencer can stall on it. The read port serves microinstruction fetch with one cycle of latency.

Top module: `cs_store_loader`

## Requirements
- R1: `cpu_rst` is 1 from reset until the edge that writes address 511 from the image. At that edge it falls, exactly 512*(IMG_LAT+1) rising edges after reset release, and it stays 0 until the next reset.
- R2: The image memory sees a one-cycle `img_rd` pulse every IMG_LAT+1 cycles, starting in the first cycle after reset. `img_addr` runs upward from 0 to 511, one value per pulse. No pulse occurs once the copy is done.
- R3: The word on `img_data` exactly IMG_LAT cycles after a request is stored at the requested address. After the copy, every address reads back its image word.
- R4: `wcs_ready` is 1 only when `cpu_rst` is 0 and no commit is in progress. A `wcs_valid` seen while `wcs_ready` is 0 changes nothing.
- R5: An accepted command writes `{reg_d, reg_c, reg_b, reg_a}` (A in bits 15:0, B in 31:16, C in 47:32, D in 63:48) to the address `wcs_sp[8:0]`. Bits 15:9 of `wcs_sp` are ignored.
- R6: `wcs_busy` is 1 in exactly the cycle that follows an acceptance, and the RAM is written at the end of that cycle.
- R7: `rd_data` shows the word at the `rd_addr` sampled on the previous edge. A read on the same edge as a write to that address returns the old word.
- R8: A write command raised while the copy is running is not accepted and does not change the store.
- R9: If `wcs_valid` is held high, one command is accepted every second cycle. The data present on the cycles in between is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low external reset |
| img_rd | output | 1 | Image memory read request (one-cycle pulse) |
| img_addr | output | 9 | Image memory word address |
| img_data | input | 64 | Image memory data, valid IMG_LAT cycles after the request |
| cpu_rst | output | 1 | Reset held on the processor core until the copy finishes |
| wcs_valid | input | 1 | Runtime write command valid |
| wcs_ready | output | 1 | Runtime write command ready |
| wcs_sp | input | 16 | Stack pointer; low 9 bits select the destination word |
| reg_a | input | 16 | Data bits 15:0 |
| reg_b | input | 16 | Data bits 31:16 |
| reg_c | input | 16 | Data bits 47:32 |
| reg_d | input | 16 | Data bits 63:48 |
| wcs_busy | output | 1 | Commit in progress; microsequencer stalls |
| rd_addr | input | 9 | Fetch address |
| rd_data | output | 64 | Fetched microword, one cycle after `rd_addr` |

## Verification
The hardest case to reach from the ports is a read and a runtime write that hit the same word on the same edge. It only happens in the single commit cycle that follows an acceptance. The stimulus moves `rd_addr` onto the destination while `wcs_busy` is high, so the fetch and the commit share that edge. A command is also raised in the middle of the copy, aimed at a word that has already been copied, and the full read-back sweep afterwards shows it left no trace. A held `wcs_valid` with data that changes every cycle shows which words were taken and which were dropped.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int CS_ADDR_W = 9;
  localparam int CS_WORD_W = 64;
  localparam int CS_REG_W  = 16;
  localparam int CS_IMG_LAT = 3;

  typedef enum logic [1:0] {
    BT_ISSUE,
    BT_WAIT,
    BT_DONE
  } boot_st_e;
endpackage

// File: rtl/cs_boot_ctrl.sv
module cs_boot_ctrl
  import cs_pkg::*;
#(
  parameter int ADDR_W  = CS_ADDR_W,
  parameter int WORD_W  = CS_WORD_W,
  parameter int IMG_LAT = CS_IMG_LAT
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              img_rd,
  output logic [ADDR_W-1:0] img_addr,
  input  logic [WORD_W-1:0] img_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              cpu_rst
);
  localparam int LAT_W = $clog2(IMG_LAT + 1);

  boot_st_e          st;
  logic [ADDR_W-1:0] addr;
  logic [LAT_W-1:0]  lat;
  logic              lat_done;

  assign lat_done = (lat == LAT_W'(IMG_LAT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= BT_ISSUE;
      addr    <= '0;
      lat     <= '0;
      cpu_rst <= 1'b1;
    end else begin
      case (st)
        BT_ISSUE: begin
          lat <= LAT_W'(1);
          st  <= BT_WAIT;
        end
        BT_WAIT: begin
          if (lat_done) begin
            if (&addr) begin
              st      <= BT_DONE;
              cpu_rst <= 1'b0;
            end else begin
              addr <= addr + 1'b1;
              st   <= BT_ISSUE;
            end
          end else begin
            lat <= lat + LAT_W'(1);
          end
        end
        default: st <= BT_DONE;
      endcase
    end
  end

  assign img_rd   = (st == BT_ISSUE);
  assign img_addr = addr;
  assign wr_en    = (st == BT_WAIT) && lat_done;
  assign wr_addr  = addr;
  assign wr_data  = img_data;

  // R2
  img_rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    img_rd |=> !img_rd);
  // R1
  rst_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rst |=> !cpu_rst);
  // R1
  rst_release_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rst) |-> $past(wr_en && (&wr_addr)));
  // R2
  no_rd_after_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rst |-> !img_rd);
endmodule

// File: rtl/cs_wr_seq.sv
module cs_wr_seq
  import cs_pkg::*;
#(
  parameter int ADDR_W = CS_ADDR_W,
  parameter int WORD_W = CS_WORD_W,
  parameter int REG_W  = CS_REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [REG_W-1:0]  sp,
  input  logic [WORD_W-1:0] regs,
  output logic              busy,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data
);
  logic accept;
  logic unused_sp_hi;

  assign unused_sp_hi = ^sp[REG_W-1:ADDR_W];
  assign cmd_ready    = enable && !busy;
  assign accept       = cmd_valid && cmd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      busy <= accept;
      if (accept) begin
        wr_addr <= sp[ADDR_W-1:0];
        wr_data <= regs;
      end
    end
  end

  assign wr_en = busy;

  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> busy);
  // R9
  busy_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);
  // R5
  addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (wr_addr == $past(sp[ADDR_W-1:0])));
endmodule

// File: rtl/cs_ram.sv
module cs_ram
  import cs_pkg::*;
#(
  parameter int ADDR_W = CS_ADDR_W,
  parameter int WORD_W = CS_WORD_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
    if (we) mem[waddr] <= wdata;
  end
endmodule

// File: rtl/cs_store_loader.sv
module cs_store_loader
  import cs_pkg::*;
#(
  parameter int ADDR_W  = CS_ADDR_W,
  parameter int REG_W   = CS_REG_W,
  parameter int IMG_LAT = CS_IMG_LAT
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                img_rd,
  output logic [ADDR_W-1:0]   img_addr,
  input  logic [4*REG_W-1:0]  img_data,
  output logic                cpu_rst,
  input  logic                wcs_valid,
  output logic                wcs_ready,
  input  logic [REG_W-1:0]    wcs_sp,
  input  logic [REG_W-1:0]    reg_a,
  input  logic [REG_W-1:0]    reg_b,
  input  logic [REG_W-1:0]    reg_c,
  input  logic [REG_W-1:0]    reg_d,
  output logic                wcs_busy,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [4*REG_W-1:0]  rd_data
);
  localparam int WORD_W = 4 * REG_W;

  logic              boot_we, seq_we, ram_we;
  logic [ADDR_W-1:0] boot_wa, seq_wa, ram_wa;
  logic [WORD_W-1:0] boot_wd, seq_wd, ram_wd;

  cs_boot_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .IMG_LAT(IMG_LAT)) u_boot (
    .clk(clk), .rst_n(rst_n),
    .img_rd(img_rd), .img_addr(img_addr), .img_data(img_data),
    .wr_en(boot_we), .wr_addr(boot_wa), .wr_data(boot_wd),
    .cpu_rst(cpu_rst)
  );

  cs_wr_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .REG_W(REG_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(!cpu_rst),
    .cmd_valid(wcs_valid), .cmd_ready(wcs_ready),
    .sp(wcs_sp), .regs({reg_d, reg_c, reg_b, reg_a}),
    .busy(wcs_busy),
    .wr_en(seq_we), .wr_addr(seq_wa), .wr_data(seq_wd)
  );

  always_comb begin
    if (cpu_rst) begin
      ram_we = boot_we;
      ram_wa = boot_wa;
      ram_wd = boot_wd;
    end else begin
      ram_we = seq_we;
      ram_wa = seq_wa;
      ram_wd = seq_wd;
    end
  end

  cs_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_wa), .wdata(ram_wd),
    .raddr(rd_addr), .rdata(rd_data)
  );

  // R8
  no_rt_write_in_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst |-> !seq_we);
  // R4
  single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(boot_we && seq_we));
  // R4
  ready_after_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wcs_ready |-> !cpu_rst);
endmodule

// File: tb/cs_store_loader_bench.sv
module cs_store_loader_bench;
  localparam int CLK_P = 10;
  localparam int L     = 3;
  localparam int NW    = 512;
  localparam int TOT   = NW * (L + 1);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        img_rd;
  logic [8:0]  img_addr;
  logic [63:0] img_data;
  logic        cpu_rst;
  logic        wcs_valid;
  logic        wcs_ready;
  logic [15:0] wcs_sp, reg_a, reg_b, reg_c, reg_d;
  logic        wcs_busy;
  logic [8:0]  rd_addr;
  logic [63:0] rd_data;

  int total = 0;
  int fails = 0;

  always #(CLK_P/2) clk = ~clk;

  cs_store_loader #(.ADDR_W(9), .REG_W(16), .IMG_LAT(L)) u_cs_store_loader (
    .clk(clk), .rst_n(rst_n), .img_rd(img_rd), .img_addr(img_addr),
    .img_data(img_data), .cpu_rst(cpu_rst), .wcs_valid(wcs_valid),
    .wcs_ready(wcs_ready), .wcs_sp(wcs_sp), .reg_a(reg_a), .reg_b(reg_b),
    .reg_c(reg_c), .reg_d(reg_d), .wcs_busy(wcs_busy),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [63:0] img_word(input int a);
    logic [15:0] s;
    s = 16'(a);
    return {16'h5A00 ^ s, 16'(a * 7), ~s, 16'h1234 + s};
  endfunction

  function automatic logic [63:0] pat(input int i);
    return {16'hD000 + 16'(i), 16'hC000 + 16'(i), 16'hB000 + 16'(i), 16'hA000 + 16'(i)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // reference model: updated on every rising edge
  logic [63:0] m_mem [NW];
  int          n = 0;
  bit          m_busy = 0;
  bit          rd_ok = 0;
  logic [8:0]  p_a;
  logic [63:0] p_d;
  logic [63:0] exp_rd;

  always @(posedge clk) begin
    if (!rst_n) begin
      n = 0; m_busy = 0; rd_ok = 0;
    end else begin
      bit rst_b, rdy_b;
      rst_b  = (n < TOT);
      rdy_b  = !m_busy && !rst_b;
      exp_rd = m_mem[rd_addr];
      rd_ok  = !rst_b;
      if (rst_b && (n % (L + 1)) == L) m_mem[n / (L + 1)] = img_word(n / (L + 1));
      if (m_busy) begin
        m_mem[p_a] = p_d;
        m_busy = 0;
      end else if (wcs_valid && rdy_b) begin
        p_a = wcs_sp[8:0];
        p_d = {reg_d, reg_c, reg_b, reg_a};
        m_busy = 1;
      end
      if (n < TOT + 4) n++;
    end
  end

  // image memory and per-cycle comparison
  bit         pend = 0;
  int         req_n;
  int         req_a;

  always @(negedge clk) begin
    if (!rst_n) begin
      pend = 0;
      img_data = 64'hDEAD_BEEF_DEAD_BEEF;
    end else begin
      if (pend && n == req_n + L) begin
        img_data = img_word(req_a);
        pend = 0;
      end else begin
        img_data = 64'hDEAD_BEEF_DEAD_BEEF;
      end
      // R1
      chk("R1 cpu_rst", 64'(cpu_rst), 64'(n < TOT));
      // R2
      chk("R2 img_rd", 64'(img_rd), 64'((n < TOT) && (n % (L + 1)) == 0));
      if (img_rd) begin
        chk("R2 img_addr", 64'(img_addr), 64'(n / (L + 1)));
        pend = 1; req_n = n; req_a = int'(img_addr);
      end
      // R4
      chk("R4 wcs_ready", 64'(wcs_ready), 64'(!m_busy && !(n < TOT)));
      // R6
      chk("R6 wcs_busy", 64'(wcs_busy), 64'(m_busy));
      // R7
      if (rd_ok) chk("R7 rd_data", rd_data, exp_rd);
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    #(CLK_P * 200000);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int acc;
    rst_n = 0; wcs_valid = 0; wcs_sp = 0;
    reg_a = 0; reg_b = 0; reg_c = 0; reg_d = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 reset cpu_rst", 64'(cpu_rst), 64'd1);
    chk("R4 reset ready", 64'(wcs_ready), 64'd0);
    chk("R6 reset busy", 64'(wcs_busy), 64'd0);

    // R8: command during the copy, aimed at an already copied word
    while (n < 10 * (L + 1)) @(negedge clk);
    wcs_sp = 16'h0000;
    {reg_d, reg_c, reg_b, reg_a} = 64'hFFFF_EEEE_DDDD_CCCC;
    wcs_valid = 1;
    for (int i = 0; i < 4; i++) begin
      chk("R8 ready low in boot", 64'(wcs_ready), 64'd0);
      @(negedge clk);
    end
    wcs_valid = 0;

    while (cpu_rst) @(negedge clk);
    chk("R1 release cycle", 64'(n), 64'(TOT));

    // R3: full read-back sweep (address 0 also shows R8)
    for (int a = 0; a < NW; a++) begin
      rd_addr = 9'(a);
      @(negedge clk);
      chk(a == 0 ? "R3 R8 word 0" : "R3 image word", rd_data, img_word(a));
    end

    // R5 / R6 / R7: one write with high SP bits set
    chk("R4 idle ready", 64'(wcs_ready), 64'd1);
    wcs_sp = 16'hFE05;
    reg_a = 16'h1111; reg_b = 16'h2222; reg_c = 16'h3333; reg_d = 16'h4444;
    wcs_valid = 1;
    @(negedge clk);
    wcs_valid = 0;
    chk("R6 busy after accept", 64'(wcs_busy), 64'd1);
    rd_addr = 9'd5;
    @(negedge clk);
    chk("R6 busy one cycle", 64'(wcs_busy), 64'd0);
    chk("R7 old word on write edge", rd_data, img_word(5));
    @(negedge clk);
    chk("R5 packed word", rd_data, 64'h4444_3333_2222_1111);

    // R9: held valid, data changing every cycle
    acc = 0;
    wcs_sp = 16'd20;
    wcs_valid = 1;
    for (int i = 0; i < 8; i++) begin
      {reg_d, reg_c, reg_b, reg_a} = pat(i);
      if (wcs_ready) acc++;
      @(negedge clk);
    end
    wcs_valid = 0;
    chk("R9 accept count", 64'(acc), 64'd4);
    repeat (2) @(negedge clk);
    rd_addr = 9'd20;
    @(negedge clk);
    chk("R9 last taken word", rd_data, pat(6));
    rd_addr = 9'd21;
    @(negedge clk);
    chk("R4 neighbour untouched", rd_data, img_word(21));

    summary();
    $finish;
  end
endmodule